// File: doc/BRIEF.md
# Programmable Integer Clock-Enable Divider with Update Handshake

This block turns a fast clock into a clock-enable pulse train. It raises one single-cycle pulse for every N input cycles, where N comes from an 8-bit divisor field in a control word. Software reaches the control word through four access kinds: plain write, bit-set, bit-clear and bit-toggle. The alias kinds change only the bits given as 1 in the write data. The same word carries a gate bit, which stops the output, and a fractional-select bit, which hands the output over to a neighbouring fractional divider. It also carries a wait-gating enable, a sticky error flag and a read-only busy flag.

A new divisor does not take effect at once. An accepted update sets busy, and the running period finishes on the old divisor. The new divisor is loaded at that period boundary and busy drops on the same edge, so software polls busy until it reads 0. The block refuses a divisor update while the clock is gated and flags the refusal. It ignores a zero divisor. All outputs are plain control and status pins. No data stream passes through the block, so there is no valid/ready interface.

Top module: `clkdiv_busy`

## Requirements
- R1: With gate, fractional-select and wait gating all inactive and busy clear, `clk_en` is high for exactly one cycle in every N cycles, where N is the divisor field (bits [7:0]). N=1 gives a pulse every cycle and N=255 gives one pulse per 255 cycles.
- R2: After reset, `reg_rdata` reads 0x001: divisor 1, with every flag and control bit at 0.
- R3: An update that would leave the divisor field at 0 is ignored. The field keeps its previous value, busy stays 0 and the error flag is unchanged.
- R4: An accepted divisor update sets busy from the next cycle. The current output period completes on the old divisor, the new divisor counts from the following cycle, and busy reads 0 from that same cycle. A further update while busy replaces the pending value.
- R5: A divisor update made while the gate bit (bit 9) is already 1 is refused. The divisor is unchanged and the error flag (bit 11) becomes 1. The flag stays at 1 until an access writes 1 to bit 11. If refusal and clearing happen in the same access, the flag is set.
- R6: While the gate bit is 1, `clk_en` stays low.
- R7: `reg_op` selects the access kind: 0 writes the word, 1 ORs the data in, 2 clears the bits given as 1, and 3 inverts the bits given as 1. A divisor update is any op-0 access, or any other access with a nonzero value in bits [7:0].
- R8: While the fractional-select bit (bit 8) is 1, `frac_sel` is 1 and `clk_en` stays low.
- R9: While the wait-gating enable (bit 10) is 1 and `wait_in` is high, `clk_en` stays low. When `wait_in` drops, pulses resume.
- R10: Busy (bit 12) is read-only. Writing it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Control-word access strobe, one cycle per access |
| reg_op | input | 2 | Access kind: 0 write, 1 set, 2 clear, 3 toggle |
| reg_wdata | input | DIV_W+5 | Access data |
| reg_rdata | output | DIV_W+5 | Current control word: {busy, err, wait_en, gate, frac, divisor} |
| wait_in | input | 1 | Wait request that gates the output when wait gating is enabled |
| clk_en | output | 1 | Gated clock-enable pulse |
| frac_sel | output | 1 | Fractional mode selected |
| busy | output | 1 | Divisor update pending |
| err | output | 1 | Sticky refused-update flag |

## Verification
The hardest case to reach from the ports is a divisor update that lands in the exact cycle of a period boundary, or while an earlier update is still pending. Here the old divisor must still finish its period and the pending value must be replaced without a short pulse. The stimulus reaches this case by programming a long divisor and then issuing back-to-back updates at points fixed by the pulse train. A behavioural model in the bench tracks the phase, the pending value and busy, and is compared with the outputs every cycle.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    ACC_WRITE  = 2'd0,
    ACC_SET    = 2'd1,
    ACC_CLEAR  = 2'd2,
    ACC_TOGGLE = 2'd3
  } acc_op_e;

  function automatic logic [31:0] apply_access(acc_op_e op, logic [31:0] cur, logic [31:0] wd);
    case (op)
      ACC_WRITE: apply_access = wd;
      ACC_SET:   apply_access = cur | wd;
      ACC_CLEAR: apply_access = cur & ~wd;
      default:   apply_access = cur ^ wd;
    endcase
  endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_op,
  input  logic [DIV_W+4:0] reg_wdata,
  input  logic             busy_i,
  output logic [DIV_W+4:0] word_o,
  output logic [DIV_W-1:0] div_field_o,
  output logic             upd_accept_o,
  output logic             gate_o,
  output logic             frac_o,
  output logic             wait_en_o,
  output logic             err_o
);
  localparam int CW     = DIV_W + 5;
  localparam int B_FRAC = DIV_W;
  localparam int B_GATE = DIV_W + 1;
  localparam int B_WAIT = DIV_W + 2;
  localparam int B_ERR  = DIV_W + 3;

  logic [DIV_W-1:0] div_q;
  logic             gate_q, frac_q, wait_q, err_q;
  logic [CW-1:0]    cur_word, nxt_word;
  logic [31:0]      applied;
  logic [DIV_W-1:0] cand;
  logic             touch, refuse, accept;

  assign cur_word = {busy_i, err_q, wait_q, gate_q, frac_q, div_q};
  assign applied  = apply_access(acc_op_e'(reg_op), 32'(cur_word), 32'(reg_wdata));
  assign nxt_word = applied[CW-1:0];
  assign cand     = nxt_word[DIV_W-1:0];

  // any plain write, or an alias access naming divisor bits, is an update
  assign touch  = reg_wr && ((acc_op_e'(reg_op) == ACC_WRITE) || (|reg_wdata[DIV_W-1:0]));
  assign refuse = touch && gate_q;
  assign accept = touch && !gate_q && (cand != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= DIV_W'(1);
      gate_q <= 1'b0;
      frac_q <= 1'b0;
      wait_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (reg_wr) begin
        gate_q <= nxt_word[B_GATE];
        frac_q <= nxt_word[B_FRAC];
        wait_q <= nxt_word[B_WAIT];
      end
      if (accept) div_q <= cand;
      if (refuse)                           err_q <= 1'b1;
      else if (reg_wr && reg_wdata[B_ERR])  err_q <= 1'b0;
    end
  end

  assign word_o       = cur_word;
  assign div_field_o  = div_q;
  assign upd_accept_o = accept;
  assign gate_o       = gate_q;
  assign frac_o       = frac_q;
  assign wait_en_o    = wait_q;
  assign err_o        = err_q;
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_field_i,
  input  logic             upd_accept_i,
  output logic             tick_o,
  output logic             busy_o
);
  logic [DIV_W-1:0] act_q, cnt_q;
  logic             busy_q;

  assign tick_o = (cnt_q == act_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= DIV_W'(1);
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (tick_o) begin
        cnt_q <= '0;
        // pending value is loaded only on a period boundary
        if (busy_q) act_q <= div_field_i;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
      if (upd_accept_i) busy_q <= 1'b1;
      else if (tick_o)  busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic tick_i,
  input  logic gate_i,
  input  logic frac_i,
  input  logic wait_en_i,
  input  logic wait_in_i,
  output logic clk_en_o
);
  logic hold;
  assign hold     = gate_i | frac_i | (wait_en_i & wait_in_i);
  assign clk_en_o = tick_i & ~hold;
endmodule

// File: rtl/clkdiv_busy.sv
module clkdiv_busy #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_op,
  input  logic [DIV_W+4:0] reg_wdata,
  output logic [DIV_W+4:0] reg_rdata,
  input  logic             wait_in,
  output logic             clk_en,
  output logic             frac_sel,
  output logic             busy,
  output logic             err
);
  logic [DIV_W-1:0] div_field;
  logic             accept, tick, gate, frac, wait_en, busy_w;

  clkdiv_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_op(reg_op),
    .reg_wdata(reg_wdata), .busy_i(busy_w), .word_o(reg_rdata),
    .div_field_o(div_field), .upd_accept_o(accept), .gate_o(gate),
    .frac_o(frac), .wait_en_o(wait_en), .err_o(err)
  );

  clkdiv_core #(.DIV_W(DIV_W)) core_i (
    .clk(clk), .rst_n(rst_n), .div_field_i(div_field),
    .upd_accept_i(accept), .tick_o(tick), .busy_o(busy_w)
  );

  clkdiv_gate gate_i (
    .tick_i(tick), .gate_i(gate), .frac_i(frac), .wait_en_i(wait_en),
    .wait_in_i(wait_in), .clk_en_o(clk_en)
  );

  assign busy     = busy_w;
  assign frac_sel = frac;
endmodule

// File: rtl/clkdiv_busy_chk.sv
module clkdiv_busy_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_op,
  input logic [DIV_W+4:0] reg_wdata,
  input logic [DIV_W+4:0] reg_rdata,
  input logic             wait_in,
  input logic             clk_en,
  input logic             busy,
  input logic             err
);
  logic upd;
  assign upd = reg_wr && ((reg_op == 2'd0) || (|reg_wdata[DIV_W-1:0]));

  a_r6_gate_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DIV_W+1] |-> !clk_en);

  a_r8_frac_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DIV_W] |-> !clk_en);

  a_r9_wait_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DIV_W+2] && wait_in) |-> !clk_en);

  a_r5_gated_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && reg_rdata[DIV_W+1]) |=> (err && reg_rdata[DIV_W-1:0] == $past(reg_rdata[DIV_W-1:0])));

  a_r3_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DIV_W-1:0] != '0);

  a_r4_busy_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr));
endmodule

bind clkdiv_busy clkdiv_busy_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_op(reg_op),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_in(wait_in),
  .clk_en(clk_en), .busy(busy), .err(err)
);

// File: tb/clkdiv_busy_tb_top.sv
module clkdiv_busy_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int CW = DW + 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_op = 2'd0;
  logic [CW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_rdata;
  logic          wait_in = 1'b0;
  logic          clk_en, frac_sel, busy, err;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_busy #(.DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_op(reg_op),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_in(wait_in),
    .clk_en(clk_en), .frac_sel(frac_sel), .busy(busy), .err(err)
  );

  // behavioural reference model
  int m_div, m_pend, m_ph;
  bit m_busy, m_gate, m_frac, m_wfi, m_err;

  function automatic logic [CW-1:0] m_word();
    return {m_busy, m_err, m_wfi, m_gate, m_frac, 8'(m_pend)};
  endfunction

  function automatic bit m_clk_en();
    return (m_ph == m_div - 1) && !m_gate && !m_frac && !(m_wfi && wait_in);
  endfunction

  always @(posedge clk) begin : model
    logic [CW-1:0] cur, nw;
    bit tick, upd, old_gate;
    int cand;
    if (!rst_n) begin
      m_div = 1; m_pend = 1; m_ph = 0;
      m_busy = 0; m_gate = 0; m_frac = 0; m_wfi = 0; m_err = 0;
    end else begin
      cur = m_word();
      case (reg_op)
        2'd0: nw = reg_wdata;
        2'd1: nw = cur | reg_wdata;
        2'd2: nw = cur & ~reg_wdata;
        default: nw = cur ^ reg_wdata;
      endcase
      upd = reg_wr && (reg_op == 2'd0 || reg_wdata[7:0] != 0);
      cand = int'(nw[7:0]);
      old_gate = m_gate;
      tick = (m_ph == m_div - 1);
      if (tick) begin
        m_ph = 0;
        if (m_busy) begin m_div = m_pend; m_busy = 0; end
      end else m_ph++;
      if (reg_wr) begin
        m_frac = nw[8]; m_gate = nw[9]; m_wfi = nw[10];
      end
      if (upd && old_gate) m_err = 1;
      else begin
        if (reg_wr && reg_wdata[11]) m_err = 0;
        if (upd && cand != 0) begin m_pend = cand; m_busy = 1; end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", "clk_en vs model", int'(clk_en), int'(m_clk_en()));
      check("R4", "busy vs model", int'(busy), int'(m_busy));
      check("R5", "err vs model", int'(err), int'(m_err));
      check("R7", "word vs model", int'(reg_rdata), int'(m_word()));
      check("R8", "frac_sel vs model", int'(frac_sel), int'(m_frac));
    end
  end

  task automatic access(input logic [1:0] op, input logic [CW-1:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_op = op; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_op = 2'd0; reg_wdata = '0;
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_en) c++;
    end
  endtask

  task automatic wait_idle(output int waited);
    waited = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!busy) break;
      waited++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      finish_run();
    end
  end

  initial begin
    int c, w;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R2", "reset word", int'(reg_rdata), 1);
    check("R2", "reset busy", int'(busy), 0);
    count_pulses(10, c);
    check("R1", "divide by 1 pulses", c, 10);

    access(2'd0, 13'd4);
    check("R4", "busy after write", int'(busy), 1);
    wait_idle(w);
    count_pulses(40, c);
    check("R1", "divide by 4 pulses", c, 10);

    access(2'd0, 13'd0);
    check("R3", "zero keeps divisor", int'(reg_rdata[7:0]), 4);
    check("R3", "zero no busy", int'(busy), 0);

    access(2'd1, 13'h200);
    check("R7", "set gate keeps divisor", int'(reg_rdata[7:0]), 4);
    count_pulses(20, c);
    check("R6", "gated pulses", c, 0);

    access(2'd1, 13'h003);
    check("R5", "gated update refused", int'(reg_rdata[7:0]), 4);
    check("R5", "err raised", int'(err), 1);
    access(2'd2, 13'h200);
    check("R5", "err sticky", int'(err), 1);
    access(2'd1, 13'h800);
    check("R5", "err cleared by 1", int'(err), 0);

    access(2'd3, 13'h006);
    check("R7", "toggle divisor", int'(reg_rdata[7:0]), 2);
    wait_idle(w);
    count_pulses(20, c);
    check("R1", "divide by 2 pulses", c, 10);

    access(2'd2, 13'h002);
    check("R3", "clear to zero ignored", int'(reg_rdata[7:0]), 2);

    access(2'd1, 13'h1000);
    check("R10", "busy not writable", int'(busy), 0);

    access(2'd1, 13'h100);
    check("R8", "frac_sel", int'(frac_sel), 1);
    count_pulses(20, c);
    check("R8", "frac pulses", c, 0);
    access(2'd2, 13'h100);

    access(2'd1, 13'h400);
    wait_in = 1'b1;
    count_pulses(20, c);
    check("R9", "wait gated pulses", c, 0);
    wait_in = 1'b0;
    count_pulses(20, c);
    check("R9", "wait released pulses", c, 10);
    access(2'd2, 13'h400);

    // boundary: long period, then back-to-back updates while pending
    access(2'd0, 13'd8);
    wait_idle(w);
    repeat (3) @(posedge clk);
    access(2'd0, 13'd3);
    check("R4", "busy after mid-period write", int'(busy), 1);
    access(2'd0, 13'd5);
    wait_idle(w);
    check("R4", "busy clears within period", int'(w <= 8), 1);
    count_pulses(50, c);
    check("R4", "replaced pending divisor", c, 10);

    access(2'd0, 13'd255);
    wait_idle(w);
    count_pulses(510, c);
    check("R1", "divide by 255 pulses", c, 2);

    finish_run();
  end
endmodule